// File: doc/BRIEF.md
# Dual-buffer frame fetch sequencer

This block prepares each frame fetch for a display panel controller whose pixels sit in one or two frame buffers in memory. Each buffer is given by a top and a bottom byte address. On a frame request the block checks that the buffer bounds lie inside the addressable window and picks the current buffer. It then reads the palette block at the head of that buffer through a single-outstanding read port and forwards every word to a palette store. From the first palette word it decodes the pixel depth, places the start of the pixel data behind the header, and checks that the whole frame fits inside the buffer.

A clean setup marks the buffer in a sticky channel condition vector, may pulse the channel interrupt and a frame-done strobe, and, in dual mode, swaps to the other buffer for the next frame. A frame that does not fit raises a sticky sync error and switches the panel off until the enable input is taken low and high again. A subpanel setting can move the first displayed line or shorten the frame. The pixel transfer and line drawing are left to the logic downstream.

Top module: `ffs_top`

## Requirements
- R1: After reset `busy_o`, `run_o`, `sync_err_o`, `cond_o`, `rd_req_o` and all strobes are 0.
- R2: A start request is ignored (no read, `busy_o` stays 0) unless the panel is running and `load_mode_i` is not 1; the panel runs from a rising edge of `enable_i` until `enable_i` falls or a sync error occurs.
- R3: A bound (buffer 0 top/bottom always, buffer 1 top/bottom only when `dual_i` = 1) outside `[MEM_LO, MEM_HI]` sets `cond_o[2]`, pulses `chan_irq_o` only when `irq_en_i[1]` = 1, issues no read and completes no frame.
- R4: When `load_mode_i` is not 2, the block reads `PAL_WORDS` 16-bit words from consecutive even addresses starting at the current buffer's top and presents word i on `pal_data_o` with `pal_idx_o` = i and `pal_we_o` = 1; with load mode 2 no read is made and the last decoded format is reused.
- R5: The format code is bits 14:12 of palette word 0: code 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4..7 = 16 bpp; the pixel data starts 0x200 bytes after the top for code 3 and 0x20 bytes after it otherwise; code 0 abandons the frame with no condition, error or strobe.
- R6: If offset + width*height*bpp/8 exceeds (bottom - top) + 2, `sync_err_o` is set, `run_o` drops, no condition bit is set and no frame-done strobe is given; equality still fits.
- R7: A fitting frame sets `data_base_o` = top + offset, sets `cond_o[n]` for current buffer n, pulses `frame_done_o`, and pulses `chan_irq_o` only when `irq_en_i[0]` = 1.
- R8: After each fitting frame the current buffer flips in dual mode and stays in single mode.
- R9: With `sub_en_i` = 1 and `sub_first_i` = 1, `first_line_o` = `sub_line_i` and `line_count_o` = height; with `sub_en_i` = 1 and `sub_first_i` = 0, `first_line_o` = 0 and `line_count_o` = `sub_line_i`; otherwise 0 and height.
- R10: `pal_done_o` pulses after the first palette load following a rising edge of `enable_i`, and not after later loads.
- R11: A rising edge of `enable_i` selects buffer 0 and clears `sync_err_o`; `cond_clr_i` clears `cond_o`.
- R12: A read request holds its address until granted, and the next request comes only after the data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Panel enable level |
| start_i | input | 1 | Frame request strobe |
| load_mode_i | input | 2 | 1 halts fetches, 2 skips the palette read, others read it |
| dual_i | input | 1 | Alternate between two buffers |
| irq_en_i | input | 2 | Bit 0 frame interrupt, bit 1 bound-error interrupt |
| cond_clr_i | input | 1 | Clear the condition vector |
| buf0_top_i | input | AW | Buffer 0 top address |
| buf0_bot_i | input | AW | Buffer 0 bottom address |
| buf1_top_i | input | AW | Buffer 1 top address |
| buf1_bot_i | input | AW | Buffer 1 bottom address |
| width_m1_i | input | DIM_W | Pixels per line minus one |
| height_m1_i | input | DIM_W | Lines per frame minus one |
| sub_en_i | input | 1 | Subpanel setting active |
| sub_first_i | input | 1 | Subpanel value is the first line (else the line count) |
| sub_line_i | input | DIM_W | Subpanel line value |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data |
| pal_we_o | output | 1 | Palette word write |
| pal_idx_o | output | PIW | Palette word index |
| pal_data_o | output | 16 | Palette word |
| busy_o | output | 1 | Setup in progress |
| run_o | output | 1 | Panel running |
| sync_err_o | output | 1 | Sticky oversize-frame error |
| cond_o | output | 3 | Sticky conditions: buffer 0 done, buffer 1 done, bound error |
| chan_irq_o | output | 1 | Channel interrupt strobe |
| frame_done_o | output | 1 | Frame setup complete strobe |
| pal_done_o | output | 1 | First palette load strobe |
| data_base_o | output | AW | Start address of pixel data |
| first_line_o | output | DIM_W | First displayed line |
| line_count_o | output | DIM_W+1 | Displayed line count |

## Verification
A start accepted on edge k leaves the bound check on edge k+1; each palette word then takes at least two edges (grant, then data) and longer when the grant is withheld, and the decode and fit result land on the edge where `busy_o` falls, together with the sticky outputs, the data base and the line outputs, while strobes stay high for exactly that one cycle. The bench drives a start in one cycle, polls `busy_o` at falling edges until it is low, and reads registered outputs there; strobe counts are read one falling edge later so the monitor that counts them has already seen the pulse. Ignored requests are checked by counting cycles with `busy_o` high over a fixed window after the request.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_PAL   = 2'd2,
    ST_DEC   = 2'd3
  } seq_state_e;

  localparam logic [1:0] LM_HALT  = 2'd1;
  localparam logic [1:0] LM_NOPAL = 2'd2;

  // Bits per pixel for a header format code; 0 marks an unsupported code.
  function automatic logic [4:0] fmt_bpp(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Byte distance from the buffer top to the first pixel.
  function automatic logic [9:0] fmt_offset(input logic [2:0] code);
    return (code == 3'd3) ? 10'h200 : 10'h020;
  endfunction

  // Bytes occupied by a frame of w x h pixels at bpp bits each.
  function automatic logic [47:0] frame_bytes(input logic [47:0] w, input logic [47:0] h,
                                               input logic [4:0] bpp);
    logic [47:0] bits;
    bits = w * h * 48'(bpp);
    return bits >> 3;
  endfunction

endpackage

// File: rtl/ffs_bound_check.sv
module ffs_bound_check #(
  parameter int          AW     = 32,
  parameter logic [AW-1:0] MEM_LO = 32'h0001_0000,
  parameter logic [AW-1:0] MEM_HI = 32'h00FF_FFFF
) (
  input  logic [AW-1:0] buf0_top_i,
  input  logic [AW-1:0] buf0_bot_i,
  input  logic [AW-1:0] buf1_top_i,
  input  logic [AW-1:0] buf1_bot_i,
  input  logic          dual_i,
  output logic          ok_o
);
  localparam int NB = 4;

  logic [AW-1:0] bnd [NB];
  logic [NB-1:0] pass;

  assign bnd[0] = buf0_top_i;
  assign bnd[1] = buf0_bot_i;
  assign bnd[2] = buf1_top_i;
  assign bnd[3] = buf1_bot_i;

  for (genvar g = 0; g < NB; g++) begin : g_bound
    if (g < 2) begin : g_always
      assign pass[g] = (bnd[g] >= MEM_LO) && (bnd[g] <= MEM_HI);
    end else begin : g_dual
      assign pass[g] = !dual_i || ((bnd[g] >= MEM_LO) && (bnd[g] <= MEM_HI));
    end
  end

  assign ok_o = &pass;
endmodule

// File: rtl/ffs_fit_check.sv
module ffs_fit_check
  import ffs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 10
) (
  input  logic [2:0]       code_i,
  input  logic [DIM_W-1:0] width_m1_i,
  input  logic [DIM_W-1:0] height_m1_i,
  input  logic [AW-1:0]    top_i,
  input  logic [AW-1:0]    bot_i,
  output logic             supported_o,
  output logic             fits_o,
  output logic [AW-1:0]    offset_o
);
  logic [4:0]         bpp;
  logic [47:0]        need;
  logic signed [63:0] avail;
  logic signed [63:0] need_s;

  always_comb begin
    bpp      = fmt_bpp(code_i);
    offset_o = AW'(fmt_offset(code_i));
    need     = 48'(fmt_offset(code_i))
             + frame_bytes(48'(width_m1_i) + 48'd1, 48'(height_m1_i) + 48'd1, bpp);
    // A bottom below the top gives a negative size in this signed form.
    avail    = 64'(bot_i) - 64'(top_i) + 64'sd2;
    need_s   = $signed({16'd0, need});
  end

  assign supported_o = (bpp != 5'd0);
  assign fits_o      = (need_s <= avail);
endmodule

// File: rtl/ffs_pal_reader.sv
module ffs_pal_reader #(
  parameter int AW    = 32,
  parameter int WORDS = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_gnt_i,
  input  logic          rd_valid_i,
  input  logic [15:0]   rd_data_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [15:0]   wr_data_o,
  output logic [2:0]    code_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic          busy_q, wait_q, done_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [2:0]    code_q;

  assign rd_req_o  = busy_q && !wait_q;
  assign rd_addr_o = base_q + AW'({idx_q, 1'b0});
  assign wr_en_o   = wait_q && rd_valid_i;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = rd_data_i;
  assign code_o    = code_q;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        wait_q <= 1'b0;
        idx_q  <= '0;
        base_q <= base_i;
      end else if (busy_q) begin
        if (rd_req_o && rd_gnt_i) wait_q <= 1'b1;
        if (wr_en_o) begin
          wait_q <= 1'b0;
          if (idx_q == '0) code_q <= rd_data_i[14:12];
          if (idx_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  // R12: an ungranted request keeps its address
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R12: a granted request is not followed by another before its data
  p_one_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_gnt_i) |=> !rd_req_o);
endmodule

// File: rtl/ffs_top.sv
module ffs_top
  import ffs_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DIM_W     = 10,
  parameter int            PAL_WORDS = 256,
  parameter logic [AW-1:0] MEM_LO    = 32'h0001_0000,
  parameter logic [AW-1:0] MEM_HI    = 32'h00FF_FFFF,
  localparam int           PIW       = $clog2(PAL_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [1:0]       load_mode_i,
  input  logic             dual_i,
  input  logic [1:0]       irq_en_i,
  input  logic             cond_clr_i,
  input  logic [AW-1:0]    buf0_top_i,
  input  logic [AW-1:0]    buf0_bot_i,
  input  logic [AW-1:0]    buf1_top_i,
  input  logic [AW-1:0]    buf1_bot_i,
  input  logic [DIM_W-1:0] width_m1_i,
  input  logic [DIM_W-1:0] height_m1_i,
  input  logic             sub_en_i,
  input  logic             sub_first_i,
  input  logic [DIM_W-1:0] sub_line_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_gnt_i,
  input  logic             rd_valid_i,
  input  logic [15:0]      rd_data_i,
  output logic             pal_we_o,
  output logic [PIW-1:0]   pal_idx_o,
  output logic [15:0]      pal_data_o,
  output logic             busy_o,
  output logic             run_o,
  output logic             sync_err_o,
  output logic [2:0]       cond_o,
  output logic             chan_irq_o,
  output logic             frame_done_o,
  output logic             pal_done_o,
  output logic [AW-1:0]    data_base_o,
  output logic [DIM_W-1:0] first_line_o,
  output logic [DIM_W:0]   line_count_o
);
  seq_state_e state_q;
  logic en_q, run_q, cur_ok_q, cur_q, sync_q, pal_loaded_q;
  logic chan_irq_q, frame_done_q, pal_done_q;
  logic [2:0]       cond_q, hdr_code_q;
  logic [AW-1:0]    data_base_q;
  logic [DIM_W-1:0] first_q;
  logic [DIM_W:0]   lines_q;

  // Named events shared by the sequencer and the assertions
  logic en_rise, start_ok, bounds_ok, bound_fail, pal_go, dec_ok, dec_sync;
  logic rdr_done, supported, fits;
  logic [2:0]    rdr_code;
  logic [AW-1:0] sel_top, sel_bot, offset;

  assign sel_top    = cur_q ? buf1_top_i : buf0_top_i;
  assign sel_bot    = cur_q ? buf1_bot_i : buf0_bot_i;
  assign en_rise    = enable_i && !en_q;
  assign start_ok   = (state_q == ST_IDLE) && start_i && run_q && cur_ok_q
                      && (load_mode_i != LM_HALT);
  assign bound_fail = (state_q == ST_CHECK) && !bounds_ok;
  assign pal_go     = (state_q == ST_CHECK) && bounds_ok && (load_mode_i != LM_NOPAL);
  assign dec_ok     = (state_q == ST_DEC) && supported && fits;
  assign dec_sync   = (state_q == ST_DEC) && supported && !fits;

  ffs_bound_check #(.AW(AW), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)) u_bounds (
    .buf0_top_i(buf0_top_i), .buf0_bot_i(buf0_bot_i),
    .buf1_top_i(buf1_top_i), .buf1_bot_i(buf1_bot_i),
    .dual_i(dual_i), .ok_o(bounds_ok)
  );

  ffs_pal_reader #(.AW(AW), .WORDS(PAL_WORDS), .IW(PIW)) u_reader (
    .clk(clk), .rst_n(rst_n), .go_i(pal_go), .base_i(sel_top),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_en_o(pal_we_o), .wr_idx_o(pal_idx_o), .wr_data_o(pal_data_o),
    .code_o(rdr_code), .done_o(rdr_done)
  );

  ffs_fit_check #(.AW(AW), .DIM_W(DIM_W)) u_fit (
    .code_i(hdr_code_q), .width_m1_i(width_m1_i), .height_m1_i(height_m1_i),
    .top_i(sel_top), .bot_i(sel_bot),
    .supported_o(supported), .fits_o(fits), .offset_o(offset)
  );

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_ok) state_q <= ST_CHECK;
        ST_CHECK: if (!bounds_ok)                    state_q <= ST_IDLE;
                  else if (load_mode_i == LM_NOPAL)   state_q <= ST_DEC;
                  else                                state_q <= ST_PAL;
        ST_PAL:   if (rdr_done) state_q <= ST_DEC;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // Panel state, buffer selection and results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      run_q        <= 1'b0;
      cur_ok_q     <= 1'b0;
      cur_q        <= 1'b0;
      sync_q       <= 1'b0;
      pal_loaded_q <= 1'b0;
      cond_q       <= '0;
      hdr_code_q   <= '0;
      chan_irq_q   <= 1'b0;
      frame_done_q <= 1'b0;
      pal_done_q   <= 1'b0;
      data_base_q  <= '0;
      first_q      <= '0;
      lines_q      <= '0;
    end else begin
      en_q <= enable_i;

      if (!enable_i)     run_q <= 1'b0;
      else if (en_rise)  run_q <= 1'b1;
      else if (dec_sync) run_q <= 1'b0;

      if (!enable_i) begin
        cur_ok_q <= 1'b0;
      end else if (en_rise) begin
        cur_ok_q <= 1'b1;
        cur_q    <= 1'b0;
      end else if (dec_ok && dual_i) begin
        cur_q    <= !cur_q;
      end

      if (en_rise)       sync_q <= 1'b0;
      else if (dec_sync) sync_q <= 1'b1;

      if (en_rise)       pal_loaded_q <= 1'b0;
      else if (rdr_done) pal_loaded_q <= 1'b1;
      pal_done_q <= rdr_done && !pal_loaded_q && !en_rise;

      if (rdr_done) hdr_code_q <= rdr_code;

      if (cond_clr_i) cond_q <= '0;
      if (bound_fail) cond_q[2] <= 1'b1;
      if (dec_ok)     cond_q[cur_q] <= 1'b1;

      chan_irq_q   <= (bound_fail && irq_en_i[1]) || (dec_ok && irq_en_i[0]);
      frame_done_q <= dec_ok;

      if (dec_ok) begin
        data_base_q <= sel_top + offset;
        first_q     <= (sub_en_i && sub_first_i) ? sub_line_i : '0;
        lines_q     <= (sub_en_i && !sub_first_i) ? {1'b0, sub_line_i}
                                                  : ((DIM_W+1)'(height_m1_i) + 1'b1);
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign run_o        = run_q;
  assign sync_err_o   = sync_q;
  assign cond_o       = cond_q;
  assign chan_irq_o   = chan_irq_q;
  assign frame_done_o = frame_done_q;
  assign pal_done_o   = pal_done_q;
  assign data_base_o  = data_base_q;
  assign first_line_o = first_q;
  assign line_count_o = lines_q;

  // R2: halted load mode keeps the sequencer idle
  p_halt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && load_mode_i == LM_HALT) |=> (state_q == ST_IDLE));

  // R3: a bound failure ends the setup without any read
  p_bound_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bound_fail |=> (!rd_req_o && state_q == ST_IDLE && cond_o[2]));

  // R4: the palette-skip mode starts no read
  p_nopal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && load_mode_i == LM_NOPAL) |=> !rd_req_o);

  // R6: an oversize frame turns the panel off and flags the error
  p_sync_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sync |=> (!run_o && sync_err_o && !frame_done_o));

  // R7: a fitting frame marks its buffer and strobes frame done
  p_done_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ok |=> (frame_done_o && cond_o[$past(cur_q)]));

  // R8: dual mode swaps the buffer, single mode keeps it
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && dual_i && enable_i) |=> (cur_q != $past(cur_q)));
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && !dual_i && enable_i) |=> (cur_q == $past(cur_q)));

  // R11: a rising enable clears the error and selects buffer 0
  p_en_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!sync_err_o && !cur_q && run_o));
endmodule

// File: tb/ffs_top_tb_top.sv
`timescale 1ns/1ps
module ffs_top_tb_top;
  localparam int AW = 32;
  localparam int DW = 10;
  localparam int PW = 256;

  localparam logic [2:0] O_OK = 3'd0, O_SYNC = 3'd1, O_BND = 3'd2, O_SKIP = 3'd3, O_IGN = 3'd4;

  typedef struct packed {
    logic [1:0]  lm;
    logic        dual;
    logic [2:0]  fmt;
    logic [9:0]  wm1;
    logic [9:0]  hm1;
    logic [31:0] t0;
    logic [31:0] b0;
    logic [31:0] t1;
    logic [31:0] b1;
    logic [2:0]  outc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0001_0000, 32'h0001_027E, 32'h0007_0000, 32'h0007_1000, O_OK},
    '{2'd0, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0001_0000, 32'h0001_027D, 32'h0007_0000, 32'h0007_1000, O_SYNC},
    '{2'd3, 1'b0, 3'd1, 10'd63, 10'd3, 32'h0002_0000, 32'h0002_0100, 32'h0007_0000, 32'h0007_1000, O_OK},
    '{2'd0, 1'b0, 3'd2, 10'd31, 10'd1, 32'h0002_1000, 32'h0002_1040, 32'h0007_0000, 32'h0007_1000, O_OK},
    '{2'd0, 1'b0, 3'd5, 10'd9,  10'd9, 32'h0002_2000, 32'h0002_20E5, 32'h0007_0000, 32'h0007_1000, O_SYNC},
    '{2'd0, 1'b0, 3'd0, 10'd15, 10'd7, 32'h0003_0000, 32'h0003_1000, 32'h0007_0000, 32'h0007_1000, O_SKIP},
    '{2'd0, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0000_0100, 32'h0002_0000, 32'h0007_0000, 32'h0007_1000, O_BND},
    '{2'd0, 1'b1, 3'd3, 10'd15, 10'd7, 32'h0001_0000, 32'h0001_1000, 32'h0100_0000, 32'h0100_1000, O_BND},
    '{2'd0, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0004_0000, 32'h0004_1000, 32'h0100_0000, 32'h0100_1000, O_OK},
    '{2'd2, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0004_0000, 32'h0004_1000, 32'h0007_0000, 32'h0007_1000, O_OK},
    '{2'd1, 1'b0, 3'd3, 10'd15, 10'd7, 32'h0004_0000, 32'h0004_1000, 32'h0007_0000, 32'h0007_1000, O_IGN}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, start = 1'b0, dual = 1'b0, cond_clr = 1'b0;
  logic [1:0] lm = 2'd0, irq_en = 2'b11;
  logic [AW-1:0] t0 = '0, b0 = '0, t1 = '0, b1 = '0;
  logic [DW-1:0] wm1 = '0, hm1 = '0, sub_line = '0;
  logic sub_en = 1'b0, sub_first = 1'b0;
  logic rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic [2:0] mem_fmt = 3'd0;

  logic rd_req, pal_we, busy, run, sync_err, chan_irq, frame_done, pal_done;
  logic [AW-1:0] rd_addr, data_base;
  logic [7:0] pal_idx;
  logic [15:0] pal_data;
  logic [2:0] cond;
  logic [DW-1:0] first_line;
  logic [DW:0] line_count;

  int n_chk = 0, n_fail = 0;
  int cnt_fd = 0, cnt_irq = 0, cnt_pd = 0, cnt_we = 0, cnt_busy = 0;
  logic [15:0] first_word = '0, last_word = '0;

  ffs_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .start_i(start), .load_mode_i(lm),
    .dual_i(dual), .irq_en_i(irq_en), .cond_clr_i(cond_clr),
    .buf0_top_i(t0), .buf0_bot_i(b0), .buf1_top_i(t1), .buf1_bot_i(b1),
    .width_m1_i(wm1), .height_m1_i(hm1), .sub_en_i(sub_en), .sub_first_i(sub_first),
    .sub_line_i(sub_line), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .pal_we_o(pal_we), .pal_idx_o(pal_idx),
    .pal_data_o(pal_data), .busy_o(busy), .run_o(run), .sync_err_o(sync_err),
    .cond_o(cond), .chan_irq_o(chan_irq), .frame_done_o(frame_done), .pal_done_o(pal_done),
    .data_base_o(data_base), .first_line_o(first_line), .line_count_o(line_count)
  );

  always #4 clk = !clk;

  function automatic logic [15:0] mk_word(input logic [31:0] a);
    return {1'b0, mem_fmt, a[12:1]};
  endfunction

  // Memory model: settles 1 ns after each rising edge, grant withheld every third cycle
  logic pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int gcnt = 0;
  always @(posedge clk) begin
    logic g;
    #1;
    g = (gcnt % 3) != 2;
    gcnt++;
    rd_valid  = pend;
    rd_data   = mk_word(pend_addr);
    pend      = rd_req && g;
    pend_addr = rd_addr;
    rd_gnt    = g;
  end

  always @(negedge clk) begin
    if (frame_done) cnt_fd++;
    if (chan_irq)   cnt_irq++;
    if (pal_done)   cnt_pd++;
    if (busy)       cnt_busy++;
    if (pal_we) begin
      cnt_we++;
      if (pal_idx == 8'd0) first_word = pal_data;
      last_word = pal_data;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_off(input logic [2:0] f);
    if (f == 3'd3) return 32'd512;
    return 32'd32;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic re_enable();
    @(negedge clk); enable = 1'b0;
    cycles(2);
    enable = 1'b1;
    cycles(2);
  endtask

  task automatic clear_cond();
    @(negedge clk); cond_clr = 1'b1;
    @(negedge clk); cond_clr = 1'b0;
  endtask

  int s_fd, s_irq, s_pd, s_we, s_busy;
  task automatic snap();
    s_fd = cnt_fd; s_irq = cnt_irq; s_pd = cnt_pd; s_we = cnt_we; s_busy = cnt_busy;
  endtask

  // One start request; waits for the setup to finish, then one extra falling edge
  task automatic frame();
    int c;
    snap();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 0;
    while (busy && c < 5000) begin
      @(negedge clk);
      c++;
    end
    if (c >= 5000) begin
      n_chk++; n_fail++;
      $display("FAIL R12: setup never finished, actual busy %0d expected 0", busy);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 run", run, 0);
    chk("R1 cond", cond, 0);
    chk("R1 sync", sync_err, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 strobes", {frame_done, pal_done, chan_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    // R2: start before enable is ignored
    snap();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles(4);
    chk("R2 not running", cnt_busy - s_busy, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      lm = v.lm; dual = v.dual; mem_fmt = v.fmt; wm1 = v.wm1; hm1 = v.hm1;
      t0 = v.t0; b0 = v.b0; t1 = v.t1; b1 = v.b1; irq_en = 2'b11;
      clear_cond();
      re_enable();
      if (v.outc == O_IGN) begin
        snap();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cycles(6);
        chk($sformatf("R2 halt mode v%0d busy", i), cnt_busy - s_busy, 0);
        chk($sformatf("R2 halt mode v%0d reads", i), cnt_we - s_we, 0);
        continue;
      end
      frame();
      case (v.outc)
        O_OK: begin
          chk($sformatf("R7 v%0d done", i), cnt_fd - s_fd, 1);
          chk($sformatf("R7 v%0d cond", i), cond, 3'b001);
          chk($sformatf("R5 v%0d base", i), data_base, v.t0 + exp_off(v.fmt));
          chk($sformatf("R7 v%0d irq", i), cnt_irq - s_irq, 1);
          chk($sformatf("R9 v%0d lines", i), line_count, 64'(v.hm1) + 1);
          chk($sformatf("R6 v%0d no sync", i), {run, sync_err}, 2'b10);
        end
        O_SYNC: begin
          chk($sformatf("R6 v%0d sync", i), sync_err, 1);
          chk($sformatf("R6 v%0d run off", i), run, 0);
          chk($sformatf("R6 v%0d no done", i), cnt_fd - s_fd, 0);
          chk($sformatf("R6 v%0d cond", i), cond, 0);
        end
        O_BND: begin
          chk($sformatf("R3 v%0d cond", i), cond, 3'b100);
          chk($sformatf("R3 v%0d irq", i), cnt_irq - s_irq, 1);
          chk($sformatf("R3 v%0d reads", i), cnt_we - s_we, 0);
          chk($sformatf("R3 v%0d done", i), cnt_fd - s_fd, 0);
        end
        default: begin
          chk($sformatf("R5 v%0d skip", i), {cnt_fd - s_fd, 32'(cond), 32'(sync_err)}, 0);
          chk($sformatf("R5 v%0d still running", i), run, 1);
        end
      endcase
      if (v.outc != O_BND) begin
        if (v.lm == 2'd2) begin
          chk($sformatf("R4 v%0d no reads", i), cnt_we - s_we, 0);
          chk($sformatf("R10 v%0d no pal done", i), cnt_pd - s_pd, 0);
        end else begin
          chk($sformatf("R12 v%0d word count", i), cnt_we - s_we, PW);
          chk($sformatf("R4 v%0d first word", i), first_word, {1'b0, v.fmt, v.t0[12:1]});
          chk($sformatf("R4 v%0d last word", i), last_word,
              mk_word(v.t0 + 32'd510));
          chk($sformatf("R10 v%0d pal done", i), cnt_pd - s_pd, 1);
        end
      end
    end

    // Dual buffers alternate
    lm = 2'd0; dual = 1'b1; mem_fmt = 3'd3; wm1 = 10'd15; hm1 = 10'd7;
    t0 = 32'h0005_0000; b0 = 32'h0005_1000; t1 = 32'h0006_0000; b1 = 32'h0006_1000;
    clear_cond();
    re_enable();
    frame();
    chk("R8 dual first base", data_base, 32'h0005_0200);
    chk("R10 first load strobe", cnt_pd - s_pd, 1);
    frame();
    chk("R8 dual second base", data_base, 32'h0006_0200);
    chk("R4 second buffer header", first_word, {1'b0, 3'd3, t1[12:1]});
    chk("R10 later load no strobe", cnt_pd - s_pd, 0);
    chk("R7 both buffers marked", cond, 3'b011);
    frame();
    chk("R8 dual back to buffer 0", data_base, 32'h0005_0200);
    // Now on buffer 1; re-enable must return to buffer 0
    re_enable();
    frame();
    chk("R11 enable selects buffer 0", data_base, 32'h0005_0200);

    // Single mode stays on buffer 0
    dual = 1'b0;
    re_enable();
    frame();
    frame();
    chk("R8 single keeps buffer 0", data_base, 32'h0005_0200);

    // Subpanel
    sub_en = 1'b1; sub_first = 1'b1; sub_line = 10'd5;
    frame();
    chk("R9 first line", {first_line, line_count}, {10'd5, 11'd8});
    sub_first = 1'b0; sub_line = 10'd3;
    frame();
    chk("R9 override count", {first_line, line_count}, {10'd0, 11'd3});
    sub_en = 1'b0;

    // Interrupt enables
    irq_en = 2'b00;
    frame();
    chk("R7 irq masked", cnt_irq - s_irq, 0);
    t0 = 32'h0000_0010;
    frame();
    chk("R3 irq masked", cnt_irq - s_irq, 0);
    chk("R3 bound flag", cond[2], 1);
    clear_cond();
    chk("R11 cond cleared", cond, 0);

    // After a sync error, requests are ignored until enable toggles
    irq_en = 2'b11; t0 = 32'h0001_0000; b0 = 32'h0001_0010;
    re_enable();
    frame();
    chk("R6 sync raised", {sync_err, run}, 2'b10);
    snap();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles(4);
    chk("R2 ignored after sync", cnt_busy - s_busy, 0);
    re_enable();
    chk("R11 sync cleared", {sync_err, run}, 2'b01);
    @(negedge clk); enable = 1'b0;
    cycles(2);
    chk("R11 disable stops run", run, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule